// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a serial link to a single-channel 14-bit successive-approximation converter. It drives an active-low chip select and a serial clock that idles high, and it samples the converter's data line on each rising clock edge, most significant bit first. The serial clock is the system clock divided by an even parameter.

Three kinds of frame exist. A 24-clock power-up calibration frame runs on its own right after reset. A 64-clock calibration frame runs on request. A 24-clock conversion frame returns one 14-bit result, which is taken from a fixed window of the received bits. A request carries a channel mask, a resolution code and a calibration flag. The block checks the request first. It then services the mask one channel at a time, lowest index first, and emits each result with a one-cycle valid strobe and the channel index. A one-cycle done pulse closes the request.

Between frames, chip select stays high for at least a programmable number of system clocks, so that the converter has time to acquire the next sample.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The serial clock is high whenever chip select is high. Data is sampled on each rising serial-clock edge, and the first sampled bit is the oldest bit of the frame.
- R2: Out of reset, `busy` is high. A 24-clock calibration frame starts without any request, and the data line is ignored during it. No result is produced. `busy` falls when that frame ends.
- R3: A request with `calReq` high first runs one 64-clock calibration frame. The conversion frames of the request, if any, follow it.
- R4: Every conversion frame has exactly 24 serial-clock falling edges, and never fewer than 18.
- R5: Number the sampled bits of a conversion frame 1 to 24. The result is sampled bits 2 to 15, with bit 2 as the result MSB. Bit 1 and bits 16 to 24 do not affect the result.
- R6: A request is rejected in either of two cases: `resolution` is not 14, or any mask bit at index NUM_CH or above is set. A rejected request gives a one-cycle `reqErr` pulse and starts no frame, and `busy` stays low.
- R7: Mask channels are converted in ascending index order, one conversion frame each. Each result appears with `resultCh` equal to its channel index.
- R8: Between the end of one frame and the start of the next, chip select stays high for at least CS_GAP system clocks.
- R9: The serial-clock period is CLK_DIV system clocks. The first falling edge comes CLK_DIV/2 system clocks after chip select falls.
- R10: `done` pulses for one cycle, one cycle after the last `resultValid` of the request, with `busy` low. A request with an empty mask and no calibration gives `done` without any frame.
- R11: A `start` pulse while `busy` is high is ignored. The running request produces exactly its own frames and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| chMask | input | MASK_W | Channels to convert |
| resolution | input | 5 | Requested result width, must be 14 |
| calReq | input | 1 | Run an operating calibration frame first |
| spiMiso | input | 1 | Serial data from converter |
| busy | output | 1 | Request or power-up frame in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| reqErr | output | 1 | One-cycle request rejection pulse |
| resultValid | output | 1 | One-cycle result strobe |
| result | output | 14 | Conversion result |
| resultCh | output | CH_W | Channel of the current result |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock, idles high |

## Verification
The assertions assume that `start` only counts while the control is idle. They also assume that every frame the converter sees is started by this block, so the falling-edge and gap counters begin from a chip-select fall that the block itself produced. The bench changes the data line only on serial-clock falling edges, and it issues requests only after `busy` has dropped, except for the one deliberate pulse that checks R11. Requests sweep all channel masks, with and without calibration. Result values are drawn from an arithmetic sequence over the frame index that includes all-zeros and all-ones, and junk bits are placed outside the result window.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int RES_BITS  = 14;
  localparam int BOOT_CLKS = 24;
  localparam int CAL_CLKS  = 64;
  localparam int CONV_CLKS = 24;
  localparam int MIN_FALLS = 18;

  typedef enum logic [1:0] {FK_BOOT, FK_CAL, FK_CONV} frame_kind_t;

  typedef struct packed {
    logic        startFrame;
    frame_kind_t kind;
  } dp_ctrl_t;

  typedef struct packed {
    logic idle;
    logic frameDone;
  } dp_stat_t;
endpackage

// File: rtl/adcf_datapath.sv
module adcf_datapath
  import adcf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            ctrl,
  output dp_stat_t            stat,
  input  logic                spiMiso,
  output logic                spiCsN,
  output logic                spiSclk,
  output logic                resValid,
  output logic [RES_BITS-1:0] result
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int HALF_W = $clog2(2 * CAL_CLKS + 1);
  localparam int GAP_W  = $clog2(CS_GAP + 2);
  localparam int SH_W   = CONV_CLKS;
  localparam int FALL_W = $clog2(CAL_CLKS + 1);

  logic              active;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt, lastHalf;
  logic [GAP_W-1:0]  gapCnt;
  logic [SH_W-1:0]   shiftQ;
  frame_kind_t       kindQ;
  logic              frameDoneQ;

  always_comb begin
    case (kindQ)
      FK_CAL:  lastHalf = HALF_W'(2 * CAL_CLKS);
      FK_BOOT: lastHalf = HALF_W'(2 * BOOT_CLKS);
      default: lastHalf = HALF_W'(2 * CONV_CLKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      spiCsN     <= 1'b1;
      spiSclk    <= 1'b1;
      divCnt     <= '0;
      halfCnt    <= '0;
      gapCnt     <= '0;
      shiftQ     <= '0;
      kindQ      <= FK_BOOT;
      frameDoneQ <= 1'b0;
      resValid   <= 1'b0;
      result     <= '0;
    end else begin
      frameDoneQ <= 1'b0;
      resValid   <= 1'b0;
      if (!active) begin
        if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
        if (ctrl.startFrame) begin
          active  <= 1'b1;
          spiCsN  <= 1'b0;
          spiSclk <= 1'b1;
          divCnt  <= '0;
          halfCnt <= '0;
          kindQ   <= ctrl.kind;
        end
      end else if (divCnt == DIV_W'(HALF - 1)) begin
        divCnt <= '0;
        if (halfCnt == lastHalf) begin
          active     <= 1'b0;
          spiCsN     <= 1'b1;
          gapCnt     <= GAP_W'(CS_GAP);
          frameDoneQ <= 1'b1;
          if (kindQ == FK_CONV) begin
            resValid <= 1'b1;
            result   <= shiftQ[SH_W-2 -: RES_BITS];
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
          spiSclk <= ~spiSclk;
          if (!spiSclk) shiftQ <= {shiftQ[SH_W-2:0], spiMiso};
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign stat.idle      = !active && (gapCnt == '0);
  assign stat.frameDone = frameDoneQ;

  logic [FALL_W-1:0] fallCnt;
  logic [GAP_W-1:0]  csHighCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallCnt   <= '0;
      csHighCnt <= GAP_W'(CS_GAP);
    end else begin
      if (!active && ctrl.startFrame) fallCnt <= '0;
      else if (active && divCnt == DIV_W'(HALF - 1) && halfCnt != lastHalf && spiSclk)
        fallCnt <= fallCnt + 1'b1;
      if (!spiCsN) csHighCnt <= '0;
      else if (csHighCnt < GAP_W'(CS_GAP)) csHighCnt <= csHighCnt + 1'b1;
    end
  end

  AST_CS_HIGH_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> spiSclk); // R1
  AST_CONV_MIN_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    (frameDoneQ && kindQ == FK_CONV) |-> (fallCnt >= FALL_W'(MIN_FALLS))); // R4
  AST_CS_GAP_MET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (csHighCnt >= GAP_W'(CS_GAP))); // R8
  AST_LEAD_HALF_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (spiSclk && divCnt == '0)); // R9
endmodule

// File: rtl/adcf_control.sv
module adcf_control
  import adcf_pkg::*;
#(
  parameter int MASK_W = 4,
  parameter int NUM_CH = 1,
  localparam int CH_W  = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MASK_W-1:0] chMask,
  input  logic [4:0]        resolution,
  input  logic              calReq,
  input  dp_stat_t          stat,
  output dp_ctrl_t          ctrl,
  output logic              busy,
  output logic              done,
  output logic              reqErr,
  output logic [CH_W-1:0]   curCh
);
  typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_CAL, ST_CONV} ctl_state_t;

  ctl_state_t        state;
  logic              issued;
  logic [MASK_W-1:0] pending, validMask, pendNext;
  logic              badReq;

  for (genvar g = 0; g < MASK_W; g++) begin : gen_valid
    assign validMask[g] = (g < NUM_CH);
  end

  function automatic logic [CH_W-1:0] lowIdx(input logic [MASK_W-1:0] m);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = MASK_W - 1; i >= 0; i--) if (m[i]) idx = CH_W'(i);
    return idx;
  endfunction

  assign badReq   = (resolution != 5'(RES_BITS)) || |(chMask & ~validMask);
  assign pendNext = pending & ~(MASK_W'(1) << curCh);

  always_comb begin
    ctrl.startFrame = (state != ST_IDLE) && !issued && stat.idle;
    case (state)
      ST_BOOT: ctrl.kind = FK_BOOT;
      ST_CAL:  ctrl.kind = FK_CAL;
      default: ctrl.kind = FK_CONV;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      issued  <= 1'b0;
      pending <= '0;
      curCh   <= '0;
      done    <= 1'b0;
      reqErr  <= 1'b0;
    end else begin
      done   <= 1'b0;
      reqErr <= 1'b0;
      if (ctrl.startFrame) begin
        issued <= 1'b1;
        if (state == ST_CONV) curCh <= lowIdx(pending);
      end
      case (state)
        ST_BOOT: if (stat.frameDone) begin
          issued <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_IDLE: if (start) begin
          if (badReq) reqErr <= 1'b1;
          else begin
            pending <= chMask;
            if (calReq) state <= ST_CAL;
            else if (|chMask) state <= ST_CONV;
            else done <= 1'b1;
          end
        end
        ST_CAL: if (stat.frameDone) begin
          issued <= 1'b0;
          if (|pending) state <= ST_CONV;
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: if (stat.frameDone) begin
          issued  <= 1'b0;
          pending <= pendNext;
          if (pendNext == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  logic bootSeen;
  always_ff @(posedge clk) begin
    if (!rstN) bootSeen <= 1'b0;
    else if (ctrl.startFrame) bootSeen <= 1'b1;
  end

  AST_FIRST_FRAME_BOOT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.startFrame && !bootSeen) |-> (ctrl.kind == FK_BOOT)); // R2
  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (!busy && !ctrl.startFrame)); // R6
  AST_CONV_CH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.startFrame && ctrl.kind == FK_CONV) |-> validMask[lowIdx(pending)]); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adcf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 8,
  parameter int MASK_W  = 4,
  parameter int NUM_CH  = 1,
  localparam int CH_W   = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MASK_W-1:0] chMask,
  input  logic [4:0]        resolution,
  input  logic              calReq,
  input  logic              spiMiso,
  output logic              busy,
  output logic              done,
  output logic              reqErr,
  output logic              resultValid,
  output logic [13:0]       result,
  output logic [CH_W-1:0]   resultCh,
  output logic              spiCsN,
  output logic              spiSclk
);
  dp_ctrl_t dpCtrl;
  dp_stat_t dpStat;

  adcf_control #(.MASK_W(MASK_W), .NUM_CH(NUM_CH)) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .chMask(chMask),
    .resolution(resolution), .calReq(calReq), .stat(dpStat), .ctrl(dpCtrl),
    .busy(busy), .done(done), .reqErr(reqErr), .curCh(resultCh)
  );

  adcf_datapath #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .stat(dpStat), .spiMiso(spiMiso),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .resValid(resultValid), .result(result)
  );
endmodule

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV = 4;
  localparam int CS_GAP  = 3;
  localparam int MASK_W  = 4;
  localparam int NUM_CH  = 3;
  localparam int CH_W    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [MASK_W-1:0] chMask = '0;
  logic [4:0] resolution = 5'd14;
  logic calReq = 1'b0;
  logic spiMiso = 1'b0;
  logic busy, done, reqErr, resultValid, spiCsN, spiSclk;
  logic [13:0] result;
  logic [CH_W-1:0] resultCh;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_ctrl #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .MASK_W(MASK_W), .NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .chMask(chMask), .resolution(resolution),
    .calReq(calReq), .spiMiso(spiMiso), .busy(busy), .done(done), .reqErr(reqErr),
    .resultValid(resultValid), .result(result), .resultCh(resultCh),
    .spiCsN(spiCsN), .spiSclk(spiSclk)
  );

  int nCmp = 0, nBad = 0;
  int frStart = 0, curIdx = 0, falls = 0;
  int frLen[256];
  int resN = 0;
  int resChArr[256];
  time tFall = 0, tRise = 0;
  bit  prevValid = 0, expectRes = 0, doneSeen = 0, errSeen = 0;

  function automatic logic [13:0] valFor(int i);
    if (i % 7 == 3) return 14'h0000;
    if (i % 7 == 5) return 14'h3FFF;
    return 14'((i * 2731 + 97) % 16384);
  endfunction

  function automatic logic [23:0] patFor(int i);
    return {1'b1, valFor(i), 9'h155};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: launches bits on falling edges
  always @(negedge spiCsN) if (rstN) begin
    if (frStart > 0) chk(($time - tRise) >= CS_GAP * CLK_PERIOD, "R8 gap", int'(($time - tRise) / CLK_PERIOD), CS_GAP);
    curIdx = frStart;
    frStart++;
    falls = 0;
    tFall = $time;
    spiMiso = 1'b0;
  end

  always @(negedge spiSclk) if (rstN && !spiCsN) begin
    falls++;
    if (falls == 1) chk(($time - tFall) == (CLK_DIV/2) * CLK_PERIOD, "R9 lead", int'(($time - tFall) / CLK_PERIOD), CLK_DIV/2);
    if (falls <= 24) spiMiso = patFor(curIdx)[24 - falls];
    else spiMiso = 1'b1;
  end

  always @(posedge spiCsN) if (rstN && frStart > 0) begin
    frLen[curIdx % 256] = falls;
    tRise = $time;
    chk(spiSclk == 1'b1, "R1 sclk idle", int'(spiSclk), 1);
  end

  always @(negedge clk) begin
    if (rstN && resultValid) begin
      chk(result == valFor(frStart - 1), "R5 result", int'(result), int'(valFor(frStart - 1)));
      resChArr[resN % 256] = int'(resultCh);
      resN++;
    end
    if (rstN && done) begin
      doneSeen = 1;
      if (expectRes) chk(prevValid, "R10 done after last result", int'(prevValid), 1);
    end
    if (rstN && reqErr) errSeen = 1;
    prevValid = resultValid;
  end

  task automatic runReq(logic [MASK_W-1:0] m, bit cal, logic [4:0] res, bit poke);
    int f0, r0, nExp, k, waitC;
    bit bad;
    while (busy) @(negedge clk);
    bad = (res != 5'd14) || (m[3] == 1'b1);
    f0 = frStart; r0 = resN;
    doneSeen = 0; errSeen = 0;
    expectRes = (m & 4'b0111) != 0;
    chMask = m; calReq = cal; resolution = res; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      repeat (20) @(negedge clk);
      chk(errSeen, "R6 reqErr", int'(errSeen), 1);
      chk(frStart == f0, "R6 no frame", frStart - f0, 0);
      chk(!busy, "R6 not busy", int'(busy), 0);
      return;
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      chMask = 4'b0001; calReq = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitC = 0;
    while (!doneSeen && waitC < 5000) begin @(negedge clk); waitC++; end
    chk(doneSeen, "R10 done seen", int'(doneSeen), 1);
    nExp = $countones(m);
    chk(frStart - f0 == nExp + int'(cal), poke ? "R11 frame count" : "R10 frame count", frStart - f0, nExp + int'(cal));
    chk(resN - r0 == nExp, poke ? "R11 result count" : "R7 result count", resN - r0, nExp);
    k = 0;
    if (cal) begin
      chk(frLen[f0 % 256] == 64, "R3 cal length", frLen[f0 % 256], 64);
      k = 1;
    end
    for (int b = 0; b < MASK_W; b++) begin
      if (m[b]) begin
        chk(frLen[(f0 + k) % 256] == 24, "R4 conv length", frLen[(f0 + k) % 256], 24);
        chk(resChArr[(r0 + k - int'(cal)) % 256] == b, "R7 channel order", resChArr[(r0 + k - int'(cal)) % 256], b);
        k++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spiCsN && spiSclk, "R1 reset idle", int'({spiCsN, spiSclk}), 3);
    chk(busy, "R2 busy in reset", int'(busy), 1);
    chk(!resultValid && !done, "R2 reset strobes", int'({resultValid, done}), 0);
    rstN = 1'b1;
    while (busy) @(negedge clk);
    chk(frStart == 1, "R2 boot frames", frStart, 1);
    chk(frLen[0] == 24, "R2 boot length", frLen[0], 24);
    chk(resN == 0, "R2 boot no result", resN, 0);
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 16; m++)
        runReq(4'(m), bit'(c), 5'd14, 1'b0);
    runReq(4'b0001, 1'b0, 5'd12, 1'b0);
    runReq(4'b0010, 1'b1, 5'd16, 1'b0);
    runReq(4'b0111, 1'b0, 5'd14, 1'b1);
    for (int v = 0; v < 24; v++) runReq(4'(1 << (v % 3)), 1'b0, 5'd14, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule